// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block collects interrupt requests from a set of I/O devices and turns them into one interrupt line for the processor's control sequencer. Every device presents a ready flag, an interrupt-enable bit, a fixed 3-bit priority and an 8-bit vector. A device counts as requesting only when both its ready flag and its enable bit are set. A priority encoder picks the strongest request, and the line to the sequencer is raised only when that priority is strictly above the processor's running priority level. A keyboard device, for example, would normally carry vector 0x80.

A small state machine drives the line. In IDLE the line is low. The transition IDLE to ASSERT happens when a qualifying request is seen. ASSERT returns to IDLE when the qualification goes away. ASSERT moves to SETTLE when the sequencer pulses its acknowledge while a request still qualifies, and the winner's vector and priority are captured at that edge. SETTLE always returns to IDLE on the next edge, which keeps the line low long enough for the sequencer to install the new level. The captured priority is the level the sequencer adopts for the service routine. The captured values hold until the next accepted acknowledge.

Top module: `irq_arbiter`

## Requirements
- R1: A device takes part in arbitration only when its ready bit and its enable bit are both 1. A device with either bit at 0 never wins and never raises the line.
- R2: Among requesting devices, the one with the numerically largest 3-bit priority wins.
- R3: When several requesting devices share the largest priority, the one with the lowest index wins.
- R4: The line is raised only when the winning priority is strictly greater than `cur_level`. An equal priority does not raise it, and with `cur_level` = 7 it never rises.
- R5: The line rises one clock edge after a qualifying request appears. Without an acknowledge, it falls one edge after qualification is lost.
- R6: An acknowledge sampled while the line is high and a request qualifies loads the winner's vector into `int_vec` and its priority into `int_level` at that edge. The line is then low for exactly two cycles, even if the request persists.
- R7: An acknowledge sampled while the line is low is ignored, and `int_vec` and `int_level` keep their values.
- R8: `int_vec` and `int_level` change only on an accepted acknowledge. Changes to device inputs or to `cur_level` leave them unchanged.
- R9: A synchronous active-high reset clears `int_req`, `int_vec` and `int_level` to 0 and returns the machine to IDLE.
- R10: With no requesting device, the line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_ready | input | NUM_DEV | Ready flag per device |
| dev_ie | input | NUM_DEV | Interrupt-enable bit per device |
| dev_prio | input | NUM_DEV*3 | Priority per device; device i in bits [3i+2:3i] |
| dev_vec | input | NUM_DEV*VEC_W | Vector per device; device i in bits [VEC_W*i +: VEC_W] |
| cur_level | input | 3 | Processor's running priority level |
| int_ack | input | 1 | Acknowledge pulse from the sequencer |
| int_req | output | 1 | Interrupt line to the sequencer |
| int_vec | output | VEC_W | Vector captured on the last accepted acknowledge |
| int_level | output | 3 | Priority captured on the last accepted acknowledge |

## Verification
The hardest case to reach is the SETTLE window. In it, the request is still qualifying but the line must stay low for two cycles after an acknowledge. A bench that clears its requests after every handshake would never expose this window. The directed test therefore keeps a qualifying device asserted through the acknowledge and samples the line on each of the three following cycles. A second directed test removes qualification only by raising `cur_level`, with no acknowledge, so that the ASSERT to IDLE path is taken.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LEVEL_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ASSERT = 2'd1,
        ST_SETTLE = 2'd2
    } irq_state_e;
endpackage

// File: rtl/irq_request_mask.sv
module irq_request_mask #(
    parameter int NUM_DEV = 4
) (
    input  logic [NUM_DEV-1:0] ready,
    input  logic [NUM_DEV-1:0] enable,
    output logic [NUM_DEV-1:0] pending
);
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_mask
        assign pending[i] = ready[i] & enable[i];
    end
endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder #(
    parameter int NUM_DEV = 4,
    parameter int PRIO_W  = 3,
    parameter int VEC_W   = 8
) (
    input  logic [NUM_DEV-1:0]        pending,
    input  logic [NUM_DEV*PRIO_W-1:0] prio_flat,
    input  logic [NUM_DEV*VEC_W-1:0]  vec_flat,
    output logic                      found,
    output logic [PRIO_W-1:0]         best_prio,
    output logic [VEC_W-1:0]          best_vec
);
    // Ascending scan; replacement only on strictly larger priority,
    // so ties keep the lowest index.
    always_comb begin
        found     = 1'b0;
        best_prio = '0;
        best_vec  = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (pending[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] > best_prio)) begin
                found     = 1'b1;
                best_prio = prio_flat[i*PRIO_W +: PRIO_W];
                best_vec  = vec_flat[i*VEC_W +: VEC_W];
            end
        end
    end
endmodule

// File: rtl/irq_ctrl_fsm.sv
module irq_ctrl_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic qualify,
    input  logic ack,
    output logic req,
    output logic capture
);
    irq_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (qualify) state_nx = ST_ASSERT;
            ST_ASSERT: begin
                if (!qualify)  state_nx = ST_IDLE;
                else if (ack)  state_nx = ST_SETTLE;
            end
            ST_SETTLE: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req     = (state == ST_ASSERT);
        capture = (state == ST_ASSERT) && qualify && ack;
    end
endmodule

// File: rtl/irq_vector_latch.sv
module irq_vector_latch #(
    parameter int PRIO_W = 3,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [VEC_W-1:0]  vec_in,
    input  logic [PRIO_W-1:0] prio_in,
    output logic [VEC_W-1:0]  vec_q,
    output logic [PRIO_W-1:0] prio_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q  <= '0;
            prio_q <= '0;
        end else if (load) begin
            vec_q  <= vec_in;
            prio_q <= prio_in;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int VEC_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_DEV-1:0]         dev_ready,
    input  logic [NUM_DEV-1:0]         dev_ie,
    input  logic [NUM_DEV*LEVEL_W-1:0] dev_prio,
    input  logic [NUM_DEV*VEC_W-1:0]   dev_vec,
    input  logic [LEVEL_W-1:0]         cur_level,
    input  logic                       int_ack,
    output logic                       int_req,
    output logic [VEC_W-1:0]           int_vec,
    output logic [LEVEL_W-1:0]         int_level
);
    logic [NUM_DEV-1:0] pending;
    logic               found;
    logic [LEVEL_W-1:0] win_prio;
    logic [VEC_W-1:0]   win_vec;
    logic               qualify;
    logic               capture;

    irq_request_mask #(.NUM_DEV(NUM_DEV)) u_mask (
        .ready(dev_ready), .enable(dev_ie), .pending(pending)
    );

    irq_prio_encoder #(.NUM_DEV(NUM_DEV), .PRIO_W(LEVEL_W), .VEC_W(VEC_W)) u_enc (
        .pending(pending), .prio_flat(dev_prio), .vec_flat(dev_vec),
        .found(found), .best_prio(win_prio), .best_vec(win_vec)
    );

    assign qualify = found && (win_prio > cur_level);

    irq_ctrl_fsm u_fsm (
        .clk(clk), .rst(rst), .qualify(qualify), .ack(int_ack),
        .req(int_req), .capture(capture)
    );

    irq_vector_latch #(.PRIO_W(LEVEL_W), .VEC_W(VEC_W)) u_latch (
        .clk(clk), .rst(rst), .load(capture),
        .vec_in(win_vec), .prio_in(win_prio),
        .vec_q(int_vec), .prio_q(int_level)
    );
endmodule

// File: rtl/irq_arbiter_checker.sv
module irq_arbiter_checker #(
    parameter int NUM_DEV = 4,
    parameter int VEC_W   = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_DEV-1:0]   dev_ready,
    input logic [NUM_DEV-1:0]   dev_ie,
    input logic [NUM_DEV*3-1:0] dev_prio,
    input logic [NUM_DEV*VEC_W-1:0] dev_vec,
    input logic [2:0]           cur_level,
    input logic                 int_ack,
    input logic                 int_req,
    input logic [VEC_W-1:0]     int_vec,
    input logic [2:0]           int_level
);
    logic any_en;
    logic any_above;

    always_comb begin
        any_en    = 1'b0;
        any_above = 1'b0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (dev_ready[i] && dev_ie[i]) begin
                any_en = 1'b1;
                if (dev_prio[i*3 +: 3] > cur_level) any_above = 1'b1;
            end
        end
    end

    assert_req_needs_enabled_R1: assert property (@(posedge clk) disable iff (rst)
        int_req |-> $past(any_en));

    assert_req_above_level_R4: assert property (@(posedge clk) disable iff (rst)
        int_req |-> $past(any_above));

    assert_fall_reason_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(int_req) |-> ($past(int_ack) || !$past(any_above)));

    assert_ack_captures_R6: assert property (@(posedge clk) disable iff (rst)
        (int_req && int_ack && any_above) |=> (!int_req && int_level > $past(cur_level)));

    assert_hold_without_ack_R8: assert property (@(posedge clk) disable iff (rst)
        !(int_req && int_ack) |=> ($stable(int_vec) && $stable(int_level)));

    assert_reset_clears_R9: assert property (@(posedge clk)
        $past(rst) |-> (!int_req && int_vec == '0 && int_level == '0));
endmodule

bind irq_arbiter irq_arbiter_checker #(.NUM_DEV(NUM_DEV), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   ready = '0;
    logic [N-1:0]   ie = '0;
    logic [N*3-1:0] prio = '0;
    logic [N*8-1:0] vec = {8'hB0, 8'hA0, 8'h90, 8'h80};
    logic [2:0]     cur = '0;
    logic           ack = 1'b0;
    logic           int_req;
    logic [7:0]     int_vec;
    logic [2:0]     int_level;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_arbiter #(.NUM_DEV(N), .VEC_W(8)) uut (
        .clk(clk), .rst(rst), .dev_ready(ready), .dev_ie(ie),
        .dev_prio(prio), .dev_vec(vec), .cur_level(cur), .int_ack(ack),
        .int_req(int_req), .int_vec(int_vec), .int_level(int_level)
    );

    typedef struct packed {
        logic [3:0]  rdy;
        logic [3:0]  en;
        logic [11:0] pr;
        logic [2:0]  lvl;
        logic        exp_req;
        logic [7:0]  exp_vec;
        logic [2:0]  exp_lvl;
    } row_t;

    // Device vectors: dev0=80, dev1=90, dev2=A0, dev3=B0. Priority field {p3,p2,p1,p0}.
    localparam row_t TBL [10] = '{
        '{4'b0001, 4'b0001, {3'd0,3'd0,3'd0,3'd3}, 3'd0, 1'b1, 8'h80, 3'd3}, // R1 both bits set
        '{4'b0001, 4'b0000, {3'd0,3'd0,3'd0,3'd3}, 3'd0, 1'b0, 8'h80, 3'd3}, // R1 enable clear, R7
        '{4'b1111, 4'b1111, {3'd2,3'd6,3'd4,3'd1}, 3'd0, 1'b1, 8'hA0, 3'd6}, // R2 highest wins
        '{4'b0110, 4'b0110, {3'd0,3'd5,3'd5,3'd0}, 3'd2, 1'b1, 8'h90, 3'd5}, // R3 tie, low index
        '{4'b1000, 4'b1000, {3'd4,3'd0,3'd0,3'd0}, 3'd4, 1'b0, 8'h90, 3'd5}, // R4 equal level
        '{4'b1000, 4'b1000, {3'd4,3'd0,3'd0,3'd0}, 3'd3, 1'b1, 8'hB0, 3'd4}, // R4 one above
        '{4'b0000, 4'b1111, {3'd7,3'd7,3'd7,3'd7}, 3'd0, 1'b0, 8'hB0, 3'd4}, // R10 none pending
        '{4'b1111, 4'b0101, {3'd7,3'd3,3'd7,3'd2}, 3'd1, 1'b1, 8'hA0, 3'd3}, // R1 masked high ones
        '{4'b1111, 4'b1111, {3'd7,3'd7,3'd7,3'd7}, 3'd7, 1'b0, 8'hA0, 3'd3}, // R4 top level
        '{4'b1111, 4'b1111, {3'd0,3'd0,3'd0,3'd0}, 3'd0, 1'b0, 8'hA0, 3'd3}  // R4 zero vs zero
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9 reset state
        check(int_req == 1'b0, "R9 reset req", int_req, 0);
        check(int_vec == 8'h00, "R9 reset vec", int_vec, 0);
        check(int_level == 3'd0, "R9 reset level", int_level, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int r = 0; r < 10; r++) begin
            ready = TBL[r].rdy; ie = TBL[r].en; prio = TBL[r].pr; cur = TBL[r].lvl;
            @(negedge clk);
            check(int_req == TBL[r].exp_req, $sformatf("table row %0d req", r), int_req, TBL[r].exp_req);
            ack = 1'b1;
            @(negedge clk);
            ack = 1'b0;
            check(int_vec == TBL[r].exp_vec, $sformatf("table row %0d vec", r), int_vec, TBL[r].exp_vec);
            check(int_level == TBL[r].exp_lvl, $sformatf("table row %0d level", r), int_level, TBL[r].exp_lvl);
            check(int_req == 1'b0, $sformatf("table row %0d req after ack", r), int_req, 0);
            ready = '0;
            repeat (2) @(negedge clk);
        end

        // R5: rise one edge after qualification, fall one edge after loss
        ready = 4'b1000; ie = 4'b1000; prio = {3'd6, 9'd0}; cur = 3'd0;
        @(negedge clk);
        check(int_req == 1'b1, "R5 rise", int_req, 1);
        cur = 3'd6;
        @(negedge clk);
        check(int_req == 1'b0, "R5 fall on level raise", int_req, 0);
        check(int_vec == 8'hA0, "R8 vec held without ack", int_vec, 8'hA0);

        // R6: persistent request, two low cycles after accepted ack
        cur = 3'd0;
        @(negedge clk);
        check(int_req == 1'b1, "R6 asserted before ack", int_req, 1);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check(int_req == 1'b0, "R6 low cycle 1", int_req, 0);
        check(int_vec == 8'hB0, "R6 vec captured", int_vec, 8'hB0);
        check(int_level == 3'd6, "R6 level captured", int_level, 6);
        @(negedge clk);
        check(int_req == 1'b0, "R6 low cycle 2", int_req, 0);
        @(negedge clk);
        check(int_req == 1'b1, "R6 reasserts", int_req, 1);

        // R8: input changes without ack leave captured values alone
        prio = {3'd7, 9'd0}; ready = 4'b1001; ie = 4'b1001;
        repeat (2) @(negedge clk);
        check(int_level == 3'd6, "R8 level held", int_level, 6);
        check(int_vec == 8'hB0, "R8 vec held", int_vec, 8'hB0);

        // R9 reset while busy
        rst = 1'b1;
        @(negedge clk);
        check(int_req == 1'b0, "R9 mid reset req", int_req, 0);
        check(int_vec == 8'h00, "R9 mid reset vec", int_vec, 0);
        check(int_level == 3'd0, "R9 mid reset level", int_level, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule